// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block chooses which pending interrupt request the processor takes next. Each cycle it compares every request source against the processor's current 5-bit priority level and registers the winning level, or zero when nothing is eligible. The sources are:

- a halt request line;
- an interval-timer event;
- four external bus request lines, one per hardware level;
- receive and transmit events from the console and from the console-storage unit;
- a 16-bit software request summary.

The sources are checked in a fixed mixed order, so the result is not simply the highest level.

When the processor takes an interrupt, it pulses an acknowledge for one cycle and presents the level it is taking. On the next cycle the block returns the vector for that level. For internal sources it also clears the request it served, and the console and console-storage levels always serve their receive side before their transmit side. External bus vectors are passed through from a per-level input bus. Clearing external requests is left to their sources.

Top module: `irq_level_arbiter`

## Requirements
- R1: After synchronous reset, `irq_level` is 0, `ack_vec_valid`, `ack_err` and `ack_vec` are 0, and every internal pending request is cleared.
- R2: An active `halt_req` gives level 0x1F whatever `cur_ipl` holds, ahead of every other source.
- R3: A pending timer request gives level 0x18 only when `cur_ipl` < 0x18. It is checked after halt and before any external level.
- R4: External levels 0x17 down to 0x14 map to `ext_req[3]` down to `ext_req[0]` and are scanned from high to low. The first scanned level that is at or below `cur_ipl` ends arbitration with level 0, so no console, storage or software request can win after that point.
- R5: If the scan finishes with no winner, a pending console receive or transmit request gives 0x14 when `cur_ipl` < 0x14. Otherwise a pending console-storage receive or transmit request gives 0x15 when `cur_ipl` < 0x15. The console is checked first even though its level is lower.
- R6: If no other source wins, the result is the index of the highest set bit of `sw_req` above `cur_ipl`. Bit 0 never wins. When `cur_ipl` >= 15, no software level is given.
- R7: `irq_level` is registered. It reflects the inputs and pending state sampled at one clock edge, becomes visible after that edge, and already includes a request set or cleared at that same edge.
- R8: An acknowledge at level 0x18 returns vector `VEC_TMR` and clears the pending timer request.
- R9: An acknowledge at level 0x14 returns `VEC_CON_RX` and clears console receive when it is pending. Otherwise it returns `VEC_CON_TX` and clears console transmit. Level 0x15 follows the same rule with `VEC_STO_RX` and `VEC_STO_TX`. If neither side is pending, the vector is 0.
- R10: An acknowledge at an external level L (0x14 to 0x17) with `ext_req[L-0x14]` set returns `ext_vec[(L-0x14)*8 +: 8]` and clears nothing. This takes precedence over the console and storage service at 0x14 and 0x15.
- R11: An acknowledge at a level above 0x17 other than 0x18 sets `ack_err`, returns vector 0 and changes no pending request.
- R12: `ack_vec_valid` is high exactly one cycle after each acknowledge cycle and low otherwise. Vector and error are 0 whenever valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_ipl | input | 5 | Current processor priority level |
| halt_req | input | 1 | Halt request level |
| tmr_evt | input | 1 | Interval-timer event pulse; sets timer pending |
| con_rx_evt | input | 1 | Console receive event pulse |
| con_tx_evt | input | 1 | Console transmit event pulse |
| sto_rx_evt | input | 1 | Console-storage receive event pulse |
| sto_tx_evt | input | 1 | Console-storage transmit event pulse |
| ext_req | input | 4 | External bus requests, bit i at level 0x14+i |
| ext_vec | input | 32 | External vectors, 8 bits per level |
| sw_req | input | 16 | Software request summary |
| ack | input | 1 | One-cycle acknowledge pulse |
| ack_level | input | 5 | Level being acknowledged |
| irq_level | output | 5 | Winning level, 0 for none |
| ack_vec_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Returned vector |
| ack_err | output | 1 | Unknown-level acknowledge |

## Verification
Directed cases put competing sources against each other at priority levels just below, equal to and above their grant levels. This shows whether the halt and timer bypasses, the early exit of the external scan, the console-before-storage order and the software mask each sit at the right boundary. Acknowledge cases with both receive and transmit pending, or with an external request sharing the console or storage level, show the input-first rule and the external precedence. Random stimulus mixes all sources with acknowledges of the currently winning level, of the shared levels and of arbitrary levels. The bench compares every cycle against a reference model, which catches ordering and clearing errors that only appear when several sources are pending at once.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int IPL_W = 5;
    localparam int VEC_W = 8;
    localparam int SW_W  = 16;

    typedef logic [IPL_W-1:0] ipl_t;
    typedef logic [VEC_W-1:0] vec_t;

    // fixed level encodings
    localparam ipl_t LVL_HALT   = 5'h1F;
    localparam ipl_t LVL_CLK    = 5'h18;
    localparam ipl_t LVL_HW_MIN = 5'h14;
    localparam ipl_t LVL_CON    = 5'h14;
    localparam ipl_t LVL_STO    = 5'h15;

    // internal request sources that the block holds and clears itself
    typedef struct packed {
        logic tmr;
        logic con_rx;
        logic con_tx;
        logic sto_rx;
        logic sto_tx;
    } pend_t;

    localparam int NSRC = $bits(pend_t);

    typedef struct packed {
        logic valid;
        logic err;
        vec_t vec;
    } ack_res_t;

    // software bits strictly above the current level
    function automatic logic [SW_W-1:0] sw_eligible(input ipl_t ipl,
                                                    input logic [SW_W-1:0] req);
        logic [SW_W-1:0] m;
        for (int i = 0; i < SW_W; i++) begin
            m[i] = (i > int'(ipl));
        end
        return req & m;
    endfunction

    // index of highest set bit, bit 0 excluded
    function automatic ipl_t sw_top(input logic [SW_W-1:0] el);
        ipl_t r;
        r = '0;
        for (int i = 1; i < SW_W; i++) begin
            if (el[i]) r = ipl_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pend_t set_i,
    input  pend_t clr_i,
    output pend_t pend_q,
    output pend_t pend_nx
);
    logic [NSRC-1:0] s_v;
    logic [NSRC-1:0] c_v;
    logic [NSRC-1:0] q_v;
    logic [NSRC-1:0] n_v;

    assign s_v = set_i;
    assign c_v = clr_i;

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        // a new event in the same cycle as a clear survives
        assign n_v[g] = (q_v[g] & ~c_v[g]) | s_v[g];

        always_ff @(posedge clk) begin
            if (rst) q_v[g] <= 1'b0;
            else     q_v[g] <= n_v[g];
        end
    end

    assign pend_q  = pend_t'(q_v);
    assign pend_nx = pend_t'(n_v);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_EXT = 4
)(
    input  ipl_t               ipl,
    input  logic               halt,
    input  pend_t              pend,
    input  logic [NUM_EXT-1:0] ext_req,
    input  logic [SW_W-1:0]    sw_req,
    output ipl_t               level
);
    logic            done;
    logic [SW_W-1:0] sw_el;

    always_comb begin
        level = '0;
        done  = 1'b0;
        sw_el = '0;

        if (halt) begin
            level = LVL_HALT;
            done  = 1'b1;
        end else if (pend.tmr && (ipl < LVL_CLK)) begin
            level = LVL_CLK;
            done  = 1'b1;
        end

        // external scan, top level first; early exit at or below ipl
        for (int i = NUM_EXT - 1; i >= 0; i--) begin
            if (!done) begin
                if ((int'(LVL_HW_MIN) + i) <= int'(ipl)) begin
                    done = 1'b1;
                end else if (ext_req[i]) begin
                    level = ipl_t'(int'(LVL_HW_MIN) + i);
                    done  = 1'b1;
                end
            end
        end

        if (!done && (pend.con_rx || pend.con_tx) && (ipl < LVL_CON)) begin
            level = LVL_CON;
            done  = 1'b1;
        end

        if (!done && (pend.sto_rx || pend.sto_tx) && (ipl < LVL_STO)) begin
            level = LVL_STO;
            done  = 1'b1;
        end

        if (!done && (int'(ipl) < SW_W - 1)) begin
            sw_el = sw_eligible(ipl, sw_req);
            level = sw_top(sw_el);
        end
    end
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
    import irq_arb_pkg::*;
#(
    parameter int   NUM_EXT    = 4,
    parameter vec_t VEC_TMR    = 8'hC0,
    parameter vec_t VEC_CON_RX = 8'hF8,
    parameter vec_t VEC_CON_TX = 8'hFC,
    parameter vec_t VEC_STO_RX = 8'hF0,
    parameter vec_t VEC_STO_TX = 8'hF4
)(
    input  logic                     ack,
    input  ipl_t                     ack_level,
    input  pend_t                    pend,
    input  logic [NUM_EXT-1:0]       ext_req,
    input  logic [NUM_EXT*VEC_W-1:0] ext_vec,
    output ack_res_t                 res,
    output pend_t                    clr
);
    localparam int LVL_HW_MAX_I = int'(LVL_HW_MIN) + NUM_EXT - 1;

    logic hit;

    always_comb begin
        res = '0;
        clr = '0;
        hit = 1'b0;
        if (ack) begin
            res.valid = 1'b1;
            if (ack_level == LVL_CLK) begin
                res.vec = VEC_TMR;
                clr.tmr = 1'b1;
            end else if (int'(ack_level) > LVL_HW_MAX_I) begin
                res.err = 1'b1;
            end else begin
                for (int i = 0; i < NUM_EXT; i++) begin
                    if ((int'(ack_level) == int'(LVL_HW_MIN) + i) && ext_req[i]) begin
                        res.vec = ext_vec[i*VEC_W +: VEC_W];
                        hit     = 1'b1;
                    end
                end
                if (!hit && (ack_level == LVL_CON)) begin
                    if (pend.con_rx) begin
                        res.vec    = VEC_CON_RX;
                        clr.con_rx = 1'b1;
                    end else if (pend.con_tx) begin
                        res.vec    = VEC_CON_TX;
                        clr.con_tx = 1'b1;
                    end
                end
                if (!hit && (ack_level == LVL_STO)) begin
                    if (pend.sto_rx) begin
                        res.vec    = VEC_STO_RX;
                        clr.sto_rx = 1'b1;
                    end else if (pend.sto_tx) begin
                        res.vec    = VEC_STO_TX;
                        clr.sto_tx = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int   NUM_EXT    = 4,
    parameter vec_t VEC_TMR    = 8'hC0,
    parameter vec_t VEC_CON_RX = 8'hF8,
    parameter vec_t VEC_CON_TX = 8'hFC,
    parameter vec_t VEC_STO_RX = 8'hF0,
    parameter vec_t VEC_STO_TX = 8'hF4
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IPL_W-1:0]         cur_ipl,
    input  logic                     halt_req,
    input  logic                     tmr_evt,
    input  logic                     con_rx_evt,
    input  logic                     con_tx_evt,
    input  logic                     sto_rx_evt,
    input  logic                     sto_tx_evt,
    input  logic [NUM_EXT-1:0]       ext_req,
    input  logic [NUM_EXT*VEC_W-1:0] ext_vec,
    input  logic [SW_W-1:0]          sw_req,
    input  logic                     ack,
    input  logic [IPL_W-1:0]         ack_level,
    output logic [IPL_W-1:0]         irq_level,
    output logic                     ack_vec_valid,
    output logic [VEC_W-1:0]         ack_vec,
    output logic                     ack_err
);
    pend_t    set_v;
    pend_t    clr_v;
    pend_t    pend_q;
    pend_t    pend_nx;
    ipl_t     level_d;
    ipl_t     level_q;
    ack_res_t res_d;
    ack_res_t res_q;

    assign set_v = '{tmr: tmr_evt, con_rx: con_rx_evt, con_tx: con_tx_evt,
                     sto_rx: sto_rx_evt, sto_tx: sto_tx_evt};

    irq_pend_bank u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .pend_q  (pend_q),
        .pend_nx (pend_nx)
    );

    // vector choice uses the state held before this cycle's events
    irq_vec_sel #(
        .NUM_EXT    (NUM_EXT),
        .VEC_TMR    (VEC_TMR),
        .VEC_CON_RX (VEC_CON_RX),
        .VEC_CON_TX (VEC_CON_TX),
        .VEC_STO_RX (VEC_STO_RX),
        .VEC_STO_TX (VEC_STO_TX)
    ) u_vsel (
        .ack       (ack),
        .ack_level (ack_level),
        .pend      (pend_q),
        .ext_req   (ext_req),
        .ext_vec   (ext_vec),
        .res       (res_d),
        .clr       (clr_v)
    );

    // arbitration sees the pending state that will be registered this edge
    irq_prio_pick #(
        .NUM_EXT (NUM_EXT)
    ) u_pick (
        .ipl     (cur_ipl),
        .halt    (halt_req),
        .pend    (pend_nx),
        .ext_req (ext_req),
        .sw_req  (sw_req),
        .level   (level_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            res_q   <= '0;
        end else begin
            level_q <= level_d;
            res_q   <= res_d;
        end
    end

    assign irq_level     = level_q;
    assign ack_vec_valid = res_q.valid;
    assign ack_vec       = res_q.vec;
    assign ack_err       = res_q.err;
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter vec_t VEC_TMR = 8'hC0
)(
    input logic              clk,
    input logic              rst,
    input logic [IPL_W-1:0]  cur_ipl,
    input logic              halt_req,
    input logic [SW_W-1:0]   sw_req,
    input logic              ack,
    input logic [IPL_W-1:0]  ack_level,
    input logic [IPL_W-1:0]  irq_level,
    input logic              ack_vec_valid,
    input logic [VEC_W-1:0]  ack_vec,
    input logic              ack_err
);
    a_r2_halt_wins: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> (irq_level == LVL_HALT));

    a_r3_timer_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_level == LVL_CLK) |-> ($past(cur_ipl) < LVL_CLK));

    a_r4_above_ipl: assert property (@(posedge clk) disable iff (rst)
        ((irq_level != '0) && (irq_level != LVL_HALT)) |-> (irq_level > $past(cur_ipl)));

    a_r6_sw_bit_set: assert property (@(posedge clk) disable iff (rst)
        ((irq_level != '0) && (irq_level < 5'd16))
            |-> ((($past(sw_req) >> irq_level) & 16'h0001) == 16'h0001));

    a_r8_timer_vec: assert property (@(posedge clk) disable iff (rst)
        (ack && (ack_level == LVL_CLK)) |=> (ack_vec == VEC_TMR) && !ack_err);

    a_r11_unknown: assert property (@(posedge clk) disable iff (rst)
        (ack && (ack_level > 5'h18)) |=> ack_err && (ack_vec == '0));

    a_r12_valid_after_ack: assert property (@(posedge clk) disable iff (rst)
        ack |=> ack_vec_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !ack_vec_valid && !ack_err && (ack_vec == '0));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
    .VEC_TMR (VEC_TMR)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cur_ipl       (cur_ipl),
    .halt_req      (halt_req),
    .sw_req        (sw_req),
    .ack           (ack),
    .ack_level     (ack_level),
    .irq_level     (irq_level),
    .ack_vec_valid (ack_vec_valid),
    .ack_vec       (ack_vec),
    .ack_err       (ack_err)
);

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;
    localparam logic [7:0] VT  = 8'hC0;
    localparam logic [7:0] VCR = 8'hF8;
    localparam logic [7:0] VCT = 8'hFC;
    localparam logic [7:0] VSR = 8'hF0;
    localparam logic [7:0] VST = 8'hF4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ipl = '0;
    logic        halt = 1'b0;
    logic        tmr_p = 1'b0, crx_p = 1'b0, ctx_p = 1'b0, srx_p = 1'b0, stx_p = 1'b0;
    logic [3:0]  ext = '0;
    logic [31:0] evec = 32'h44332211;
    logic [15:0] sw = '0;
    logic        ack = 1'b0;
    logic [4:0]  ack_lvl = '0;
    logic [4:0]  irq_level;
    logic        ack_vec_valid;
    logic [7:0]  ack_vec;
    logic        ack_err;

    // reference model state
    logic m_tmr = 1'b0, m_crx = 1'b0, m_ctx = 1'b0, m_srx = 1'b0, m_stx = 1'b0;
    logic [4:0] last_lvl = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_level_arbiter #(
        .NUM_EXT (4), .VEC_TMR (VT), .VEC_CON_RX (VCR), .VEC_CON_TX (VCT),
        .VEC_STO_RX (VSR), .VEC_STO_TX (VST)
    ) u_dut (
        .clk (clk), .rst (rst), .cur_ipl (ipl), .halt_req (halt),
        .tmr_evt (tmr_p), .con_rx_evt (crx_p), .con_tx_evt (ctx_p),
        .sto_rx_evt (srx_p), .sto_tx_evt (stx_p), .ext_req (ext), .ext_vec (evec),
        .sw_req (sw), .ack (ack), .ack_level (ack_lvl), .irq_level (irq_level),
        .ack_vec_valid (ack_vec_valid), .ack_vec (ack_vec), .ack_err (ack_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected level from R2..R6 on model state
    function automatic logic [4:0] exp_level();
        if (halt) return 5'h1F;
        if (m_tmr && ipl < 5'h18) return 5'h18;
        for (int l = 'h17; l >= 'h14; l--) begin
            if (l <= int'(ipl)) return 5'h00;
            if (ext[l - 'h14]) return 5'(l);
        end
        if ((m_crx || m_ctx) && ipl < 5'h14) return 5'h14;
        if ((m_srx || m_stx) && ipl < 5'h15) return 5'h15;
        if (ipl >= 5'd15) return 5'h00;
        for (int b = 15; b > int'(ipl); b--) begin
            if (sw[b]) return 5'(b);
        end
        return 5'h00;
    endfunction

    // one cycle: model update, clock, compare; starts and ends at negedge
    task automatic step(input string tag);
        logic [7:0] ev;
        logic       ee, ev_ok, hit;
        logic       c_t, c_cr, c_ct, c_sr, c_st;
        logic [4:0] el;
        ev = '0; ee = 1'b0; ev_ok = ack; hit = 1'b0;
        c_t = 1'b0; c_cr = 1'b0; c_ct = 1'b0; c_sr = 1'b0; c_st = 1'b0;
        if (ack) begin
            if (ack_lvl == 5'h18) begin
                ev = VT; c_t = 1'b1;
            end else if (ack_lvl > 5'h17) begin
                ee = 1'b1;
            end else begin
                if (ack_lvl >= 5'h14 && ext[ack_lvl - 5'h14]) begin
                    ev = evec[(int'(ack_lvl) - 'h14) * 8 +: 8]; hit = 1'b1;
                end
                if (!hit && ack_lvl == 5'h14) begin
                    if (m_crx) begin ev = VCR; c_cr = 1'b1; end
                    else if (m_ctx) begin ev = VCT; c_ct = 1'b1; end
                end
                if (!hit && ack_lvl == 5'h15) begin
                    if (m_srx) begin ev = VSR; c_sr = 1'b1; end
                    else if (m_stx) begin ev = VST; c_st = 1'b1; end
                end
            end
        end
        m_tmr = (m_tmr & ~c_t)  | tmr_p;
        m_crx = (m_crx & ~c_cr) | crx_p;
        m_ctx = (m_ctx & ~c_ct) | ctx_p;
        m_srx = (m_srx & ~c_sr) | srx_p;
        m_stx = (m_stx & ~c_st) | stx_p;
        el = exp_level();
        @(posedge clk);
        @(negedge clk);
        check({tag, " level"}, 32'(irq_level), 32'(el));
        check({tag, " R12 valid"}, 32'(ack_vec_valid), 32'(ev_ok));
        check({tag, " vec"}, 32'(ack_vec), 32'(ev));
        check({tag, " R11 err"}, 32'(ack_err), 32'(ee));
        last_lvl = el;
        tmr_p = 1'b0; crx_p = 1'b0; ctx_p = 1'b0; srx_p = 1'b0; stx_p = 1'b0;
        ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 level in reset", 32'(irq_level), 32'h0);
        check("R1 valid in reset", 32'(ack_vec_valid), 32'h0);
        rst = 1'b0;
        step("R1 after reset");

        // R2: halt beats everything, even at top ipl
        ipl = 5'h1F; halt = 1'b1; ext = 4'hF; sw = 16'hFFFF;
        step("R2 halt ipl1F");
        halt = 1'b0; ext = '0; sw = '0;
        step("R2 halt released");

        // R3: timer at 0x18 only below it, ahead of externals
        ipl = 5'h17; tmr_p = 1'b1; ext = 4'h8;
        step("R3 timer ipl17");
        ipl = 5'h18;
        step("R3 timer blocked ipl18");
        ipl = 5'h10;
        step("R3 timer over ext");
        ack = 1'b1; ack_lvl = 5'h18;
        step("R8 timer ack");
        step("R8 timer cleared");

        // R4: scan and early exit
        ext = 4'b1010; ipl = 5'h10;
        step("R4 top ext wins");
        ipl = 5'h16; crx_p = 1'b1; sw = 16'h8000;
        step("R4 exit at ipl");
        ext = 4'b0001; ipl = 5'h14;
        step("R4 ext at ipl blocked");
        ipl = 5'h13;
        step("R4 lowest ext");

        // R10: external vector passthrough, precedence at console level
        evec = 32'hA7B6C5D4;
        ack = 1'b1; ack_lvl = 5'h14;
        step("R10 ext over console");
        ext = 4'b0100; ack = 1'b1; ack_lvl = 5'h16;
        step("R10 ext level 16");
        ext = '0; ipl = 5'h10;
        step("R5 console pending");

        // R5/R9: console rx before tx, then storage
        ctx_p = 1'b1; srx_p = 1'b1; stx_p = 1'b1;
        step("R5 console before storage");
        ack = 1'b1; ack_lvl = 5'h14;
        step("R9 console rx first");
        ack = 1'b1; ack_lvl = 5'h14;
        step("R9 console tx next");
        ipl = 5'h14;
        step("R4 storage blocked by scan");
        ipl = 5'h13;
        ack = 1'b1; ack_lvl = 5'h15;
        step("R9 storage rx first");
        ack = 1'b1; ack_lvl = 5'h15;
        step("R9 storage tx next");
        ack = 1'b1; ack_lvl = 5'h15;
        step("R9 storage empty");

        // R6: software mask
        sw = 16'h00A1; ipl = 5'h03;
        step("R6 highest eligible");
        ipl = 5'h07;
        step("R6 none above ipl");
        sw = 16'h0001; ipl = 5'h00;
        step("R6 bit0 never");
        sw = 16'h8000; ipl = 5'h0E;
        step("R6 bit15 ipl14");
        ipl = 5'h0F;
        step("R6 ipl15 none");

        // R11: unknown levels
        ack = 1'b1; ack_lvl = 5'h1F;
        step("R11 ack halt level");
        ack = 1'b1; ack_lvl = 5'h19;
        step("R11 ack 19");
        step("R12 valid drops");

        // R7: same-edge set visible after one edge
        sw = '0; ipl = 5'h00; tmr_p = 1'b1;
        step("R7 set visible");
        ack = 1'b1; ack_lvl = 5'h18;
        step("R7 clear visible");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            ipl   = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'($urandom % 20);
            halt  = ($urandom % 16 == 0);
            tmr_p = ($urandom % 8 == 0);
            crx_p = ($urandom % 8 == 0);
            ctx_p = ($urandom % 8 == 0);
            srx_p = ($urandom % 8 == 0);
            stx_p = ($urandom % 8 == 0);
            ext   = 4'($urandom) & 4'($urandom) & 4'($urandom);
            evec  = $urandom;
            sw    = 16'($urandom) & 16'($urandom);
            ack   = ($urandom % 3 == 0);
            case ($urandom % 5)
                0: ack_lvl = last_lvl;
                1: ack_lvl = 5'h14;
                2: ack_lvl = 5'h15;
                3: ack_lvl = 5'h18;
                default: ack_lvl = 5'($urandom);
            endcase
            step("R7 random");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule